// File: doc/BRIEF.md
# Interrupt-Paced Block Transfer Engine

This engine copies a block of words from a single device data register into a memory buffer. It moves one word for each device interrupt. All of its settings come from an external register file: a device base address, the offset of the data register from that base, the start address of the buffer, the word count, a mode select, an enable bit, a start flag and an interrupt-clear pulse. Each bus access goes out on one master port that uses a request/ready handshake. A word is always fetched from the device in a read phase of its own. The value is then stored to memory in a write phase of its own. The buffer is word-addressed: word k goes to buffer start + k.

In software-started mode, a rising edge on the start flag opens a transfer. In device-started mode, a rising edge on the device interrupt opens the transfer, and that same edge also paces the first word. Both modes work only while the enable bit is set. When the index reaches the programmed count, the engine returns to idle and raises a processor interrupt. That interrupt stays high until software pulses the clear input.

Top module: `dma_irq_engine`

## Requirements
- R1: After reset, `cpuIrq` and `mReq` are low.
- R2: When `cfgMode`=0 and `cfgEnable`=1, a transfer starts on a 0-to-1 change of `cfgStart` sampled while idle. Holding `cfgStart` high after completion does not start another transfer.
- R3: When `cfgMode`=1 and `cfgEnable`=1, a rising edge of `devIrq` seen while idle starts a transfer, and that edge paces word 0. When `cfgMode`=0, device edges that arrive while idle are discarded and do not pace later words.
- R4: While `cfgEnable`=0, device edges are neither latched nor used to start a transfer, and a start-flag edge does not start one.
- R5: Before each word, the engine waits for a rising edge of `devIrq`. No bus request is made until that edge occurs.
- R6: Each word begins with a read (`mWe`=0) at `cfgBase`+`cfgOffset`. It is followed directly by a write (`mWe`=1) of the returned data to `cfgBufPtr`+k, where k counts up from 0.
- R7: While `mReq` is high and `mReady` is low, `mReq`, `mWe`, `mAddr` and `mWdata` hold their values. An access completes on a clock edge where `mReq` and `mReady` are both high.
- R8: The transfer ends when k equals `cfgCount`. With `cfgCount`=0 it ends at once, with no bus access.
- R9: At the end of a transfer, `cpuIrq` is set. It stays high until a one-cycle `cfgIrqClear` pulse clears it. If a set and a clear happen in the same cycle, the set wins.
- R10: One device edge that arrives while a word is in progress is held. It paces the next word without a further edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgMode | input | 1 | 0 = software-started, 1 = device-started |
| cfgEnable | input | 1 | Enables servicing of device interrupts and starts |
| cfgStart | input | 1 | Software start flag; acts on its rising edge |
| cfgIrqClear | input | 1 | One-cycle pulse that clears `cpuIrq` |
| cfgBase | input | ADDR_W | Device base address |
| cfgOffset | input | ADDR_W | Data register offset from the base |
| cfgBufPtr | input | ADDR_W | Buffer start address |
| cfgCount | input | CNT_W | Number of words to move |
| devIrq | input | 1 | Device interrupt line; rising edges pace the words |
| mReq | output | 1 | Master access request |
| mWe | output | 1 | 1 = write, 0 = read |
| mAddr | output | ADDR_W | Master address |
| mWdata | output | DATA_W | Master write data |
| mRdata | input | DATA_W | Master read data, valid with `mReady` |
| mReady | input | 1 | Access completes on this edge |
| cpuIrq | output | 1 | Completion interrupt to the processor |

## Verification
The hardest case to reach is a device edge that lands in the middle of a word's bus access. It has to be held in the one-deep latch and then consumed without a second edge. To create it, the bench slows the bus responder to several wait cycles per access. It then pulses `devIrq` while the read of word 0 is still stalled, and requires the whole two-word block to finish with no further pulse. The other hard case is a device edge that is dropped because it arrives while idle in software-started mode. The bench checks this by showing that no read is issued until a fresh edge comes after the start.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

  typedef enum logic [2:0] {
    stIdle,
    stCheck,
    stWait,
    stRead,
    stWrite
  } dmaState_e;

  typedef struct packed {
    logic clrIdx;
    logic incIdx;
    logic capData;
    logic setIrq;
    logic armPend;
    logic dropPend;
    logic takeEvt;
    logic busRd;
    logic busWr;
  } dmaStrobe_t;

endpackage

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgMode,
  input  logic       startGo,
  input  logic       devGo,
  input  logic       devEvt,
  input  logic       countHit,
  input  logic       mReady,
  output dmaStrobe_t strobe,
  output logic       idle
);

  dmaState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= stIdle;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      stIdle: begin
        strobe.dropPend = 1'b1;
        if (cfgMode ? devGo : startGo) begin
          strobe.clrIdx  = 1'b1;
          strobe.armPend = cfgMode;
          stateNext      = stCheck;
        end
      end
      stCheck: begin
        if (countHit) begin
          strobe.setIrq = 1'b1;
          stateNext     = stIdle;
        end else begin
          stateNext = stWait;
        end
      end
      stWait: begin
        if (devEvt) begin
          strobe.takeEvt = 1'b1;
          stateNext      = stRead;
        end
      end
      stRead: begin
        strobe.busRd = 1'b1;
        if (mReady) begin
          strobe.capData = 1'b1;
          stateNext      = stWrite;
        end
      end
      stWrite: begin
        strobe.busWr = 1'b1;
        if (mReady) begin
          strobe.incIdx = 1'b1;
          stateNext     = stCheck;
        end
      end
      default: stateNext = stIdle;
    endcase
  end

  assign idle = (state == stIdle);

  assert_wait_loops_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == stWait && !devEvt) |=> (state == stWait));

  assert_write_follows_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == stRead && mReady) |=> (state == stWrite));

endmodule

// File: rtl/dma_irq_datapath.sv
module dma_irq_datapath
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobe_t        strobe,
  input  logic              cfgEnable,
  input  logic              cfgStart,
  input  logic              cfgIrqClear,
  input  logic              devIrq,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [ADDR_W-1:0] cfgOffset,
  input  logic [ADDR_W-1:0] cfgBufPtr,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic [DATA_W-1:0] mRdata,
  output logic              startGo,
  output logic              devGo,
  output logic              devEvt,
  output logic              countHit,
  output logic [ADDR_W-1:0] mAddr,
  output logic [DATA_W-1:0] mWdata,
  output logic              cpuIrq
);

  logic [CNT_W-1:0]  idx;
  logic [DATA_W-1:0] dataReg;
  logic              pend, devQ, startQ, irqReg;
  logic [ADDR_W-1:0] devAddr, bufAddr;

  assign devGo    = devIrq & ~devQ & cfgEnable;
  assign startGo  = cfgStart & ~startQ & cfgEnable;
  assign devEvt   = pend | devGo;
  assign countHit = (idx == cfgCount);

  assign devAddr = cfgBase + cfgOffset;
  assign bufAddr = cfgBufPtr + ADDR_W'(idx);
  assign mAddr   = strobe.busWr ? bufAddr : devAddr;
  assign mWdata  = dataReg;
  assign cpuIrq  = irqReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      devQ   <= 1'b0;
      startQ <= 1'b0;
    end else begin
      devQ   <= devIrq;
      startQ <= cfgStart;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                pend <= 1'b0;
    else if (strobe.armPend)  pend <= 1'b1;
    else if (strobe.dropPend) pend <= 1'b0;
    else if (strobe.takeEvt)  pend <= pend & devGo;
    else                      pend <= pend | devGo;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              idx <= '0;
    else if (strobe.clrIdx) idx <= '0;
    else if (strobe.incIdx) idx <= idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               dataReg <= '0;
    else if (strobe.capData) dataReg <= mRdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             irqReg <= 1'b0;
    else if (strobe.setIrq) irqReg <= 1'b1;
    else if (cfgIrqClear)   irqReg <= 1'b0;
  end

  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cpuIrq && !cfgIrqClear) |=> cpuIrq);

  assert_irq_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgIrqClear && !strobe.setIrq) |=> !cpuIrq);

  assert_no_latch_disabled_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgEnable && !pend && !strobe.armPend) |=> !pend);

endmodule

// File: rtl/dma_irq_engine.sv
module dma_irq_engine
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgMode,
  input  logic              cfgEnable,
  input  logic              cfgStart,
  input  logic              cfgIrqClear,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [ADDR_W-1:0] cfgOffset,
  input  logic [ADDR_W-1:0] cfgBufPtr,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic              devIrq,
  output logic              mReq,
  output logic              mWe,
  output logic [ADDR_W-1:0] mAddr,
  output logic [DATA_W-1:0] mWdata,
  input  logic [DATA_W-1:0] mRdata,
  input  logic              mReady,
  output logic              cpuIrq
);

  dmaStrobe_t strobe;
  logic startGo, devGo, devEvt, countHit, idle;

  dma_irq_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgMode  (cfgMode),
    .startGo  (startGo),
    .devGo    (devGo),
    .devEvt   (devEvt),
    .countHit (countHit),
    .mReady   (mReady),
    .strobe   (strobe),
    .idle     (idle)
  );

  dma_irq_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cfgEnable   (cfgEnable),
    .cfgStart    (cfgStart),
    .cfgIrqClear (cfgIrqClear),
    .devIrq      (devIrq),
    .cfgBase     (cfgBase),
    .cfgOffset   (cfgOffset),
    .cfgBufPtr   (cfgBufPtr),
    .cfgCount    (cfgCount),
    .mRdata      (mRdata),
    .startGo     (startGo),
    .devGo       (devGo),
    .devEvt      (devEvt),
    .countHit    (countHit),
    .mAddr       (mAddr),
    .mWdata      (mWdata),
    .cpuIrq      (cpuIrq)
  );

  assign mReq = strobe.busRd | strobe.busWr;
  assign mWe  = strobe.busWr;

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (mReq && !mReady) |=> (mReq && $stable(mWe) && $stable(mAddr) && $stable(mWdata)));

  assert_read_first_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mReq) |-> !mWe);

  assert_disabled_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    (idle && !cfgEnable) |=> idle);

  assert_irq_from_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuIrq) |-> $past(!idle));

endmodule

// File: tb/test_dma_irq_engine.sv
module test_dma_irq_engine;

  localparam int AW = 16;
  localparam int DW = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgMode = 1'b0, cfgEnable = 1'b0, cfgStart = 1'b0, cfgIrqClear = 1'b0;
  logic [AW-1:0] cfgBase = '0, cfgOffset = '0, cfgBufPtr = '0;
  logic [CW-1:0] cfgCount = '0;
  logic          devIrq = 1'b0;
  logic          mReq, mWe, mReady = 1'b0, cpuIrq;
  logic [AW-1:0] mAddr;
  logic [DW-1:0] mWdata, mRdata = '0;

  int nVec = 0, nBad = 0;
  int lat = 0, cnt = 0, nRd = 0, nWr = 0, rdAddrBad = 0, holdBad = 0;
  logic [AW-1:0] firstAddr;
  logic [DW-1:0] rdBase = '0;
  logic [AW-1:0] logAddr [16];
  logic [DW-1:0] logData [16];

  always #5 clk = ~clk;

  dma_irq_engine #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) i_dma_irq_engine (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgEnable(cfgEnable),
    .cfgStart(cfgStart), .cfgIrqClear(cfgIrqClear), .cfgBase(cfgBase),
    .cfgOffset(cfgOffset), .cfgBufPtr(cfgBufPtr), .cfgCount(cfgCount),
    .devIrq(devIrq), .mReq(mReq), .mWe(mWe), .mAddr(mAddr), .mWdata(mWdata),
    .mRdata(mRdata), .mReady(mReady), .cpuIrq(cpuIrq)
  );

  // bus responder: grants after lat waiting negedges, logs traffic
  always @(negedge clk) begin
    if (!rstN || !mReq) begin
      mReady = 1'b0;
      cnt = 0;
    end else begin
      if (cnt == 0) firstAddr = mAddr;
      else if (mAddr != firstAddr) holdBad++;
      if (cnt >= lat) begin
        mReady = 1'b1;
        cnt = 0;
        if (mWe) begin
          if (nWr < 16) begin logAddr[nWr] = mAddr; logData[nWr] = mWdata; end
          nWr++;
        end else begin
          mRdata = rdBase + DW'(nRd);
          if (mAddr != cfgBase + cfgOffset) rdAddrBad++;
          nRd++;
        end
      end else begin
        mReady = 1'b0;
        cnt++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idleCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulseDev();
    @(negedge clk) devIrq = 1'b1;
    @(negedge clk) devIrq = 1'b0;
  endtask

  task automatic clearIrq();
    @(negedge clk) cfgIrqClear = 1'b1;
    @(negedge clk) cfgIrqClear = 1'b0;
  endtask

  task automatic freshLog();
    nRd = 0; nWr = 0; rdAddrBad = 0; holdBad = 0;
  endtask

  task automatic waitWrites(input int target);
    for (int i = 0; i < 200 && nWr < target; i++) @(negedge clk);
  endtask

  task automatic waitIrq();
    for (int i = 0; i < 300 && !cpuIrq; i++) @(negedge clk);
  endtask

  task automatic checkWords(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      check(logAddr[k] == cfgBufPtr + AW'(k), req, "write address", logAddr[k], cfgBufPtr + AW'(k));
      check(logData[k] == rdBase + DW'(k), req, "write data", logData[k], rdBase + DW'(k));
    end
  endtask

  task automatic testReset();
    check(cpuIrq == 1'b0, "R1", "cpuIrq after reset", cpuIrq, 0);
    check(mReq == 1'b0, "R1", "mReq after reset", mReq, 0);
  endtask

  task automatic testAccessMode();
    freshLog();
    lat = 2; cfgMode = 0; cfgEnable = 1;
    cfgBase = 16'h0100; cfgOffset = 16'h0004; cfgBufPtr = 16'h0400;
    cfgCount = 3; rdBase = 16'hA000;
    @(negedge clk) cfgStart = 1'b1;
    idleCycles(8);
    check(nRd == 0, "R5", "reads before device edge", nRd, 0);
    for (int k = 0; k < 3; k++) begin
      pulseDev();
      waitWrites(k + 1);
      check(nWr == k + 1, "R5", "one word per edge", nWr, k + 1);
    end
    waitIrq();
    check(cpuIrq == 1'b1, "R8", "irq at count", cpuIrq, 1);
    check(nWr == 3, "R8", "total words", nWr, 3);
    checkWords(3, "R6");
    check(rdAddrBad == 0, "R6", "read address errors", rdAddrBad, 0);
    check(holdBad == 0, "R7", "address changed while waiting", holdBad, 0);
    idleCycles(10);
    check(nRd == 3, "R2", "no restart on held start", nRd, 3);
    check(cpuIrq == 1'b1, "R9", "irq sticky", cpuIrq, 1);
    clearIrq();
    check(cpuIrq == 1'b0, "R9", "irq after clear", cpuIrq, 0);
    cfgStart = 1'b0;
  endtask

  task automatic testIrqMode();
    freshLog();
    lat = 0; cfgMode = 1; cfgEnable = 1;
    cfgBufPtr = 16'h0800; cfgCount = 2; rdBase = 16'h5500;
    pulseDev();
    waitWrites(1);
    check(nWr == 1, "R3", "start edge moves word 0", nWr, 1);
    idleCycles(6);
    check(nRd == 1, "R3", "word 1 waits for edge", nRd, 1);
    pulseDev();
    waitIrq();
    check(cpuIrq == 1'b1 && nWr == 2, "R3", "device-started block done", nWr, 2);
    checkWords(2, "R3");
    clearIrq();
  endtask

  task automatic testDisabled();
    freshLog();
    cfgEnable = 0; cfgMode = 1; cfgCount = 1;
    pulseDev(); pulseDev();
    idleCycles(6);
    check(nRd == 0, "R4", "device edge while disabled", nRd, 0);
    cfgMode = 0;
    @(negedge clk) cfgStart = 1'b1;
    idleCycles(4);
    pulseDev();
    idleCycles(6);
    check(nRd == 0 && cpuIrq == 0, "R4", "start edge while disabled", nRd, 0);
    cfgStart = 1'b0;
    idleCycles(2);
  endtask

  task automatic testIdleEdgeDropped();
    freshLog();
    cfgEnable = 1; cfgMode = 0; cfgCount = 1; rdBase = 16'h3300; cfgBufPtr = 16'h0900;
    pulseDev();
    idleCycles(3);
    check(nRd == 0, "R3", "device edge starts nothing in mode 0", nRd, 0);
    @(negedge clk) cfgStart = 1'b1;
    idleCycles(6);
    check(nRd == 0, "R3", "idle edge not kept", nRd, 0);
    pulseDev();
    waitIrq();
    check(nWr == 1 && cpuIrq == 1, "R3", "fresh edge moves word", nWr, 1);
    clearIrq();
    cfgStart = 1'b0;
  endtask

  task automatic testCountZero();
    freshLog();
    cfgMode = 0; cfgEnable = 1; cfgCount = 0;
    @(negedge clk) cfgStart = 1'b1;
    idleCycles(3);
    check(cpuIrq == 1'b1, "R8", "count 0 completes", cpuIrq, 1);
    check(nRd == 0, "R8", "count 0 no bus access", nRd, 0);
    clearIrq();
    cfgStart = 1'b0;
  endtask

  task automatic testPending();
    freshLog();
    lat = 4; cfgMode = 0; cfgEnable = 1; cfgCount = 2;
    cfgBufPtr = 16'h0C00; rdBase = 16'h7700;
    @(negedge clk) cfgStart = 1'b1;
    idleCycles(3);
    pulseDev();
    idleCycles(1);
    check(mReq == 1'b1 && mWe == 1'b0, "R10", "read stalled", mReq, 1);
    pulseDev();
    waitIrq();
    check(nWr == 2, "R10", "held edge paced word 1", nWr, 2);
    checkWords(2, "R10");
    check(holdBad == 0, "R7", "hold under stalls", holdBad, 0);
    clearIrq();
    cfgStart = 1'b0;
    lat = 0;
  endtask

  initial begin
    #2_000_000;
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    idleCycles(3);
    testReset();
    @(negedge clk) rstN = 1'b1;
    idleCycles(2);
    testReset();
    testAccessMode();
    testIrqMode();
    testDisabled();
    testIdleEdgeDropped();
    testCountZero();
    testPending();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule